// File: doc/BRIEF.md
# Serial DAC command receiver

This block is the digital front end of a single-channel voltage-output DAC. A host writes 16-bit command words over a four-wire serial port made of an active-low select, a frame sync, a serial clock and a data line. The block samples all four pins in its own, faster system clock domain. It rebuilds each word and decodes a 4-bit header. The header sends the 12-bit payload either to the DAC code latch or to a small control register.

The outputs drive the analog side of the converter: the latched code, a one-cycle update strobe, a fast/slow settling mode, a power-down request and a 2-bit reference select. When select is tied low the port also works as a three-wire link. A synchronous power-on reset clears every latch. The system clock must run at least four times faster than the fastest serial clock.

Top module: `serial_dac_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is zero: code 0, no strobe, slow mode, powered up, reference select 00.
- R2: While `csn_i` is high, serial activity is ignored. Raising `csn_i` in the middle of a frame abandons that frame without changing any output.
- R3: With `csn_i` low, a falling edge of `fs_i` starts a frame and clears the shift register. Each falling edge of `sclk_i` then shifts in one bit of `din_i`, most significant bit first, up to 16 bits.
- R4: After the 16th bit, the word commits on the next rising edge of `sclk_i`, or on a rise of `fs_i` if that comes first. The outputs change three system clock cycles after the clock edge that first samples the pin change.
- R5: If `fs_i` rises after k bits, with 1 ≤ k < 16, the word commits early. Its value is the k received bits, right-aligned and zero-filled above. A frame with no bits commits nothing.
- R6: When word bits 15 and 12 are both 0, the frame is a data write. Bits 11..0 become `code_o`.
- R7: When word bits 15 and 12 are both 1, the frame is a control write. Bits 1..0 become `refsel_o`, and bits 11..2 are ignored. The reference encoding is: 00 and 11 select the external reference, 01 selects the low internal level, and 10 selects the high internal level.
- R8: Every data or control write loads bit 14 into `fast_o` (1 selects fast mode) and bit 13 into `pdn_o` (1 requests power-down).
- R9: A frame whose bits 15 and 12 differ uses a reserved select code. It is discarded and leaves all outputs unchanged.
- R10: A data write leaves `refsel_o` unchanged, so the reference persists across later data writes.
- R11: `upd_o` is high for exactly one cycle for each data write, including a write of an unchanged code. It is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| csn_i | input | 1 | Serial select, active low, asynchronous to clk |
| fs_i | input | 1 | Frame sync, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| din_i | input | 1 | Serial data, asynchronous to clk |
| code_o | output | 12 | Latched DAC code |
| upd_o | output | 1 | One-cycle strobe when the code latch is written |
| fast_o | output | 1 | Fast settling mode selected |
| pdn_o | output | 1 | Power-down requested |
| refsel_o | output | 2 | Reference select |

## Verification
The assertions rely on the serial pins being slow next to the system clock. Two commits are never closer than two cycles, so the strobe cannot repeat back to back. Every pin level must last long enough that the synchronisers never merge or drop an edge. The stimulus holds each serial clock phase for four system cycles. It separates the frame-sync and serial-clock edges by at least four cycles and moves select only while no edge is pending. Within these limits, a behavioural pin-level model in the bench predicts every output on every cycle.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_RSVA = 2'b01,
    SEL_RSVB = 2'b10,
    SEL_CTRL = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    REF_EXT_A = 2'b00,
    REF_INT_LO = 2'b01,
    REF_INT_HI = 2'b10,
    REF_EXT_B = 2'b11
  } ref_e;

  localparam int HDR_W = 4;

  function automatic sel_e hdr_sel(input logic top_bit, input logic low_bit);
    return sel_e'({top_bit, low_bit});
  endfunction

endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] chain [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= d;
      for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];

endmodule

// File: rtl/sdr_frame.sv
module sdr_frame #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              fs,
  input  logic              fs_prev,
  input  logic              sclk,
  input  logic              sclk_prev,
  input  logic              din,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  logic              fs_fall, fs_rise, sc_fall, sc_rise;

  assign fs_fall = fs_prev & ~fs;
  assign fs_rise = ~fs_prev & fs;
  assign sc_fall = sclk_prev & ~sclk;
  assign sc_rise = ~sclk_prev & sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      commit_o <= 1'b0;
      word_o   <= '0;
    end else begin
      commit_o <= 1'b0;
      if (cs_n) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (fs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
        sh     <= '0;
      end else if (active) begin
        if (fs_rise) begin
          active <= 1'b0;
          if (cnt != '0) begin
            commit_o <= 1'b1;
            word_o   <= sh;
          end
        end else if (sc_fall && (cnt < FULL)) begin
          sh  <= {sh[WORD_W-2:0], din};
          cnt <= cnt + 1'b1;
        end else if (sc_rise && (cnt == FULL)) begin
          active   <= 1'b0;
          commit_o <= 1'b1;
          word_o   <= sh;
        end
      end
    end
  end

endmodule

// File: rtl/sdr_regs.sv
module sdr_regs
  import sdr_pkg::*;
#(
  parameter int CODE_W = 12,
  localparam int WORD_W = CODE_W + HDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o,
  output logic              fast_o,
  output logic              pdn_o,
  output logic [1:0]        refsel_o
);

  sel_e sel;
  assign sel = hdr_sel(word[WORD_W-1], word[WORD_W-4]);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o   <= '0;
      upd_o    <= 1'b0;
      fast_o   <= 1'b0;
      pdn_o    <= 1'b0;
      refsel_o <= REF_EXT_A;
    end else begin
      upd_o <= 1'b0;
      if (commit) begin
        unique case (sel)
          SEL_DATA: begin
            code_o <= word[CODE_W-1:0];
            upd_o  <= 1'b1;
            fast_o <= word[WORD_W-2];
            pdn_o  <= word[WORD_W-3];
          end
          SEL_CTRL: begin
            refsel_o <= word[1:0];
            fast_o   <= word[WORD_W-2];
            pdn_o    <= word[WORD_W-3];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_dac_rx.sv
module serial_dac_rx #(
  parameter int CODE_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_i,
  input  logic              fs_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o,
  output logic              fast_o,
  output logic              pdn_o,
  output logic [1:0]        refsel_o
);

  localparam int WORD_W = CODE_W + sdr_pkg::HDR_W;

  logic [3:0]        pins_s, pins_p;
  logic              frm_commit;
  logic [WORD_W-1:0] frm_word;

  sdr_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b1100)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d      ({csn_i, fs_i, sclk_i, din_i}),
    .q      (pins_s),
    .q_prev (pins_p)
  );

  sdr_frame #(.WORD_W(WORD_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (pins_s[3]),
    .fs        (pins_s[2]),
    .fs_prev   (pins_p[2]),
    .sclk      (pins_s[1]),
    .sclk_prev (pins_p[1]),
    .din       (pins_s[0]),
    .commit_o  (frm_commit),
    .word_o    (frm_word)
  );

  sdr_regs #(.CODE_W(CODE_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .commit   (frm_commit),
    .word     (frm_word),
    .code_o   (code_o),
    .upd_o    (upd_o),
    .fast_o   (fast_o),
    .pdn_o    (pdn_o),
    .refsel_o (refsel_o)
  );

endmodule

// File: rtl/sdr_chk.sv
module sdr_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              csn_i,
  input logic              commit,
  input logic [CODE_W+3:0] word,
  input logic [CODE_W-1:0] code_o,
  input logic              upd_o,
  input logic              fast_o,
  input logic              pdn_o,
  input logic [1:0]        refsel_o
);

  localparam int T = CODE_W + 3;

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o); // R11

  AST_CODE_NEEDS_UPD: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_o) |-> upd_o); // R6

  AST_DATA_STROBE: assert property (@(posedge clk) disable iff (rst)
    (commit && !word[T] && !word[T-3]) |=> (upd_o && code_o == $past(word[CODE_W-1:0]))); // R6

  AST_CTRL_REF: assert property (@(posedge clk) disable iff (rst)
    (commit && word[T] && word[T-3]) |=> (refsel_o == $past(word[1:0]) && !upd_o)); // R7

  AST_MODE_BITS: assert property (@(posedge clk) disable iff (rst)
    (commit && (word[T] == word[T-3])) |=> (fast_o == $past(word[T-1]) && pdn_o == $past(word[T-2]))); // R8

  AST_RSV_DROP: assert property (@(posedge clk) disable iff (rst)
    (commit && (word[T] != word[T-3])) |=> ($stable(code_o) && $stable(fast_o) && $stable(pdn_o)
                                            && $stable(refsel_o) && !upd_o)); // R9

  AST_REF_KEEP: assert property (@(posedge clk) disable iff (rst)
    (commit && !word[T] && !word[T-3]) |=> $stable(refsel_o)); // R10

  AST_CS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) && $past(csn_i, 4)) |-> !upd_o); // R2

endmodule

bind serial_dac_rx sdr_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .csn_i    (csn_i),
  .commit   (frm_commit),
  .word     (frm_word),
  .code_o   (code_o),
  .upd_o    (upd_o),
  .fast_o   (fast_o),
  .pdn_o    (pdn_o),
  .refsel_o (refsel_o)
);

// File: tb/sim_serial_dac_rx.sv
`timescale 1ns/1ps
module sim_serial_dac_rx;

  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1, fs = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [11:0] code_o;
  logic upd_o, fast_o, pdn_o;
  logic [1:0] refsel_o;

  int n_tests = 0;
  int n_fail = 0;
  int upd_n = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  serial_dac_rx u0 (
    .clk(clk), .rst(rst), .csn_i(csn), .fs_i(fs), .sclk_i(sclk), .din_i(din),
    .code_o(code_o), .upd_o(upd_o), .fast_o(fast_o), .pdn_o(pdn_o), .refsel_o(refsel_o)
  );

  // Behavioural pin-level model with a three-cycle output delay line
  logic [17:0] q[$];
  logic [17:0] exp_v = '0;
  bit m_act, m_fast, m_pdn, p_fs, p_sc;
  int m_cnt;
  logic [15:0] m_sh, m_w;
  logic [11:0] m_code;
  logic [1:0] m_ref;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_act = 0; m_cnt = 0; m_sh = '0; m_code = '0; m_fast = 0; m_pdn = 0; m_ref = '0;
      p_fs = 1; p_sc = 0;
      q.delete();
      repeat (3) q.push_back(18'h0);
      exp_v = '0;
    end else begin
      bit com, upd;
      com = 0; upd = 0;
      if (csn) begin
        m_act = 0; m_cnt = 0;
      end else if (p_fs && !fs) begin
        m_act = 1; m_cnt = 0; m_sh = '0;
      end else if (m_act) begin
        if (!p_fs && fs) begin
          m_act = 0;
          if (m_cnt > 0) begin com = 1; m_w = m_sh; end
        end else if (p_sc && !sclk && m_cnt < 16) begin
          m_sh = {m_sh[14:0], din}; m_cnt++;
        end else if (!p_sc && sclk && m_cnt == 16) begin
          m_act = 0; com = 1; m_w = m_sh;
        end
      end
      if (com) begin
        if (!m_w[15] && !m_w[12]) begin
          m_code = m_w[11:0]; m_fast = m_w[14]; m_pdn = m_w[13]; upd = 1;
        end else if (m_w[15] && m_w[12]) begin
          m_ref = m_w[1:0]; m_fast = m_w[14]; m_pdn = m_w[13];
        end
      end
      p_fs = fs; p_sc = sclk;
      q.push_back({upd, m_fast, m_pdn, m_ref, m_code});
      exp_v = q.pop_front();
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_tests++;
      if ({upd_o, fast_o, pdn_o, refsel_o, code_o} !== exp_v) begin
        n_fail++;
        $display("FAIL %s model act=%h exp=%h", cur_req,
                 {upd_o, fast_o, pdn_o, refsel_o, code_o}, exp_v);
      end
      if (upd_o) upd_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic state_chk(input string req, input logic [11:0] c, input bit f,
                           input bit p, input logic [1:0] r);
    chk(req, {fast_o, pdn_o, refsel_o, code_o}, {f, p, r, c});
  endtask

  task automatic frame(input logic [15:0] w, input int nb, input bit fs_end,
                       input bit cs_hi, input bit lat, input logic [11:0] oldc,
                       input logic [11:0] newc);
    @(negedge clk) csn = cs_hi;
    repeat (2) @(negedge clk);
    fs = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      din = w[15-i]; sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    if (nb == 16 && !fs_end) begin
      sclk = 1'b1;
      if (lat) begin
        repeat (3) @(negedge clk);
        chk("R4 latency, before", code_o, oldc);
        @(negedge clk);
        chk("R4 latency, after", code_o, newc);
      end else begin
        repeat (H) @(negedge clk);
      end
      fs = 1'b1; sclk = 1'b0;
    end else begin
      fs = 1'b1;
    end
    repeat (H + 8) @(negedge clk);
  endtask

  initial begin
    int u0n;
    repeat (5) @(negedge clk);
    state_chk("R1 reset", 12'h000, 0, 0, 2'b00);
    chk("R1 strobe", upd_o, 0);
    rst = 1'b0;
    @(negedge clk);
    state_chk("R1 after release", 12'h000, 0, 0, 2'b00);
    repeat (4) @(negedge clk);

    cur_req = "R7";
    frame(16'hD002, 16, 0, 0, 0, 0, 0);
    state_chk("R7 ctrl high ref, R8 fast", 12'h000, 1, 0, 2'b10);

    cur_req = "R4";
    u0n = upd_n;
    frame(16'h4ABC, 16, 0, 0, 1, 12'h000, 12'hABC);
    state_chk("R6 data write, R10 ref kept", 12'hABC, 1, 0, 2'b10);
    chk("R11 one strobe", upd_n - u0n, 1);

    cur_req = "R11";
    u0n = upd_n;
    frame(16'h0ABC, 16, 0, 0, 0, 0, 0);
    state_chk("R8 slow on data write", 12'hABC, 0, 0, 2'b10);
    chk("R11 strobe on same code", upd_n - u0n, 1);

    cur_req = "R9";
    u0n = upd_n;
    frame(16'h8FFF, 16, 0, 0, 0, 0, 0);
    frame(16'h1555, 16, 0, 0, 0, 0, 0);
    state_chk("R9 reserved dropped", 12'hABC, 0, 0, 2'b10);
    chk("R9 no strobe", upd_n - u0n, 0);

    cur_req = "R7";
    frame(16'hF3FD, 16, 0, 0, 0, 0, 0);
    state_chk("R7 low ref, don't-care bits, R8 pdn", 12'hABC, 1, 1, 2'b01);

    cur_req = "R2";
    u0n = upd_n;
    frame(16'h0123, 16, 0, 1, 0, 0, 0);
    state_chk("R2 select high ignored", 12'hABC, 1, 1, 2'b01);
    @(negedge clk) csn = 1'b0;
    repeat (2) @(negedge clk);
    fs = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      din = 1'b1; sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    csn = 1'b1;
    repeat (H) @(negedge clk);
    fs = 1'b1;
    repeat (H) @(negedge clk);
    csn = 1'b0;
    repeat (10) @(negedge clk);
    state_chk("R2 abort mid-frame", 12'hABC, 1, 1, 2'b01);
    chk("R2 no strobe", upd_n - u0n, 0);

    cur_req = "R5";
    u0n = upd_n;
    frame(16'hFFFF, 5, 1, 0, 0, 0, 0);
    state_chk("R5 early five bits, R3 msb first", 12'h01F, 0, 0, 2'b01);
    chk("R5 early strobe", upd_n - u0n, 1);
    u0n = upd_n;
    frame(16'hFFFF, 0, 1, 0, 0, 0, 0);
    chk("R5 empty frame no commit", upd_n - u0n, 0);
    state_chk("R5 empty frame state", 12'h01F, 0, 0, 2'b01);

    cur_req = "R4";
    frame(16'h2321, 16, 1, 0, 0, 0, 0);
    state_chk("R4 fs rise after bit 16", 12'h321, 0, 1, 2'b01);

    cur_req = "R3";
    frame(16'hB000, 16, 0, 0, 0, 0, 0);
    state_chk("R7 ext ref 00", 12'h321, 0, 1, 2'b00);
    frame(16'h9003, 16, 0, 0, 0, 0, 0);
    state_chk("R7 ext ref 11", 12'h321, 0, 0, 2'b11);
    frame(16'h05A5, 16, 0, 0, 0, 0, 0);
    state_chk("R3 pattern 5A5, R10", 12'h5A5, 0, 0, 2'b11);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule